// File: doc/BRIEF.md
# Strap-Configured Serial Flash Boot Fetcher

This block reads a boot image out of a serial NOR flash over SPI. A start pulse captures a 13-bit configuration strap word. When the device-select field of that word asks for SPI boot, the word also sets four things: which of two chip selects to drive, whether the flash takes a 16-bit or a 24-bit address, the SCLK timing, and a table index. The image begins at the byte address index × 128.

The fetcher asserts the chosen chip select and sends a standard read command followed by the start address. It then clocks in a fixed number of bytes and hands each one to the consumer over a valid/ready byte port. If the consumer stalls, SCLK parks low between bytes, so no data is lost. When the last byte has been taken, the chip select is released, and a one-cycle done pulse follows after a full SCLK period. A strap word with an unsupported setting raises an error flag and drives no chip select. Any device code other than SPI leaves the fetcher idle.

Top module: `spiBootReader`

## Requirements
- R1: A start pulse while idle latches the strap word; if strap bits [2:0] are not 3'b110 the block stays quiet: no chip select, SCLK low, no done, error low.
- R2: The flash address sent equals the 4-bit index in strap bits [6:3] multiplied by 128.
- R3: Strap bits [8:7] = 2'b10 drive only cs0N low and 2'b01 drive only cs1N low; 2'b00 and 2'b11 raise the error flag and leave both chip selects high.
- R4: Strap bit 9 = 0 sends a 16-bit address (2 bytes); 1 sends a 24-bit address (3 bytes).
- R5: Strap bit 10 = 1 (five-pin operation) raises the error flag and starts no transfer.
- R6: SCLK idles low. Clock field (strap bits [12:11]) = 2 gives phase 0: MOSI changes after falling edges and MISO is captured on rising edges. Field = 0 gives phase 1: MOSI changes on rising edges and MISO is captured on falling edges.
- R7: Clock field values 1 and 3 raise the error flag and start no transfer.
- R8: A transfer sends command byte 0x03, then the address bytes, all MSB first. It then reads BYTE_COUNT bytes MSB first and delivers them in flash-address order.
- R9: One SCLK period lasts CLK_DIV system clock cycles (CLK_DIV even, at least 2).
- R10: The chip select stays low without a break from the command through the last data byte. It goes high at least CLK_DIV cycles before done, and done is a one-cycle pulse.
- R11: outValid stays high and outByte stays unchanged until outReady is seen; while a byte waits, SCLK stays low.
- R12: Strap changes after the start pulse do not affect the running transfer; the error flag holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strap | input | 13 | Boot configuration word, sampled on start |
| start | input | 1 | One-cycle request to begin a boot fetch |
| miso | input | 1 | Serial data from flash |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to flash |
| cs0N | output | 1 | Chip select 0, active low |
| cs1N | output | 1 | Chip select 1, active low |
| outByte | output | 8 | Received byte |
| outValid | output | 1 | outByte holds a byte to be taken |
| outReady | input | 1 | Consumer accepts the byte this cycle |
| done | output | 1 | One-cycle pulse when the fetch has ended |
| err | output | 1 | Unsupported strap setting seen at the last start |

## Verification
If the bit or byte counters drift, the bench's slave model shows it within a byte time: it decodes the wrong command or address, or the data bytes come out shifted. A wrong clock phase puts MISO samples on the slave's driving edge, so every byte of that run is corrupted. A bad decode of the strap word shows as the wrong chip select, or as an error flag that is set or missing, a few cycles after start. A handshake fault shows during stalls as a byte that changes or SCLK that moves while outValid is high.

// File: rtl/spiBootPkg.sv
package spiBootPkg;

  localparam int STRAP_W = 13;
  localparam logic [2:0] DEV_SPI = 3'b110;
  localparam logic [7:0] READ_CMD = 8'h03;
  localparam logic [1:0] CSF_CS0 = 2'b10;
  localparam logic [1:0] CSF_CS1 = 2'b01;
  localparam logic [1:0] CLKF_PH1 = 2'd0;
  localparam logic [1:0] CLKF_PH0 = 2'd2;
  localparam logic [2:0] HDR_NONE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_OUTB,
    ST_GAP
  } fetchState_t;

  typedef struct packed {
    logic isSpi;
    logic cfgErr;
    logic cpha;
    logic addr24;
    logic useCs1;
  } bootCfg_t;

  typedef struct packed {
    logic       latch;
    logic       load;
    logic [2:0] hdrSel;
    logic       drive;
    logic       sample;
    logic       csOn;
  } spiStrobe_t;

endpackage

// File: rtl/spiBootDatapath.sv
module spiBootDatapath
  import spiBootPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  spiStrobe_t         strobe,
  input  logic               miso,
  output bootCfg_t           cfg,
  output logic               cs0N,
  output logic               cs1N,
  output logic               mosi,
  output logic [7:0]         rxByte
);

  logic [STRAP_W-1:0] strapQ;
  logic [7:0] txQ, rxQ, hdrByte;
  logic       mosiQ;
  logic [2:0] devF;
  logic [3:0] idxF;
  logic [1:0] csF, clkF;
  logic       awF, pinF;
  logic [23:0] baseAddr;

  always_comb begin
    devF = strapQ[2:0];
    idxF = strapQ[6:3];
    csF  = strapQ[8:7];
    awF  = strapQ[9];
    pinF = strapQ[10];
    clkF = strapQ[12:11];
    baseAddr = {13'd0, idxF, 7'd0};
    cfg.isSpi  = (devF == DEV_SPI);
    cfg.cfgErr = !(csF == CSF_CS0 || csF == CSF_CS1) || pinF ||
                 !(clkF == CLKF_PH0 || clkF == CLKF_PH1);
    cfg.cpha   = (clkF == CLKF_PH1);
    cfg.addr24 = awF;
    cfg.useCs1 = (csF == CSF_CS1);
  end

  always_comb begin
    case (strobe.hdrSel)
      3'd0:    hdrByte = READ_CMD;
      3'd1:    hdrByte = awF ? baseAddr[23:16] : baseAddr[15:8];
      3'd2:    hdrByte = awF ? baseAddr[15:8] : baseAddr[7:0];
      3'd3:    hdrByte = awF ? baseAddr[7:0] : 8'h00;
      default: hdrByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ <= '0;
      txQ    <= '0;
      rxQ    <= '0;
      mosiQ  <= 1'b0;
    end else begin
      if (strobe.latch) strapQ <= strap;
      if (strobe.load) begin
        if (cfg.cpha) begin
          txQ <= hdrByte;
        end else begin
          mosiQ <= hdrByte[7];
          txQ   <= {hdrByte[6:0], 1'b0};
        end
      end else if (strobe.drive) begin
        mosiQ <= txQ[7];
        txQ   <= {txQ[6:0], 1'b0};
      end
      if (strobe.sample) rxQ <= {rxQ[6:0], miso};
    end
  end

  assign cs0N   = !(strobe.csOn && !cfg.useCs1);
  assign cs1N   = !(strobe.csOn && cfg.useCs1);
  assign mosi   = mosiQ;
  assign rxByte = rxQ;

  AST_CS_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.csOn |-> (csF == CSF_CS0 || csF == CSF_CS1)); // R3

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(strapQ)); // R12

endmodule

// File: rtl/spiBootCtrl.sv
module spiBootCtrl
  import spiBootPkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int BYTE_COUNT = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  bootCfg_t   cfg,
  input  logic       outReady,
  output spiStrobe_t strobe,
  output logic       sclk,
  output logic       outValid,
  output logic       done,
  output logic       err
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int HCW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int MAX_BY  = 4 + BYTE_COUNT;
  localparam int BIW     = $clog2(MAX_BY + 1);
  localparam int GW      = $clog2(CLK_DIV + 1);

  fetchState_t    state;
  logic [HCW-1:0] halfCnt;
  logic           phaseHi;
  logic [2:0]     bitIdx;
  logic [BIW-1:0] byteIdx, hdrLen, nextIdx;
  logic [GW-1:0]  gapCnt;
  logic           csOnQ, errQ;
  logic           halfEnd, rise, fall, byteEnd, rxPhase, lastOut;

  always_comb begin
    halfEnd = (halfCnt == HCW'(HALF - 1));
    rise    = (state == ST_XFER) && !phaseHi && halfEnd;
    fall    = (state == ST_XFER) && phaseHi && halfEnd;
    byteEnd = fall && (bitIdx == 3'd7);
    hdrLen  = cfg.addr24 ? BIW'(4) : BIW'(3);
    rxPhase = (byteIdx >= hdrLen);
    lastOut = (byteIdx == hdrLen + BIW'(BYTE_COUNT));
    nextIdx = byteIdx + 1'b1;

    strobe.latch  = (state == ST_IDLE) && start;
    strobe.load   = ((state == ST_SETUP) && cfg.isSpi && !cfg.cfgErr) ||
                    (byteEnd && !rxPhase) ||
                    ((state == ST_OUTB) && outReady && !lastOut);
    if (state == ST_SETUP)          strobe.hdrSel = 3'd0;
    else if (nextIdx > BIW'(4))     strobe.hdrSel = HDR_NONE;
    else                            strobe.hdrSel = nextIdx[2:0];
    strobe.drive  = cfg.cpha ? rise : (fall && bitIdx != 3'd7);
    strobe.sample = cfg.cpha ? fall : rise;
    strobe.csOn   = csOnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      phaseHi <= 1'b0;
      bitIdx  <= '0;
      byteIdx <= '0;
      gapCnt  <= '0;
      csOnQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          errQ  <= 1'b0;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (!cfg.isSpi) begin
            state <= ST_IDLE;
          end else if (cfg.cfgErr) begin
            errQ  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            csOnQ   <= 1'b1;
            halfCnt <= '0;
            phaseHi <= 1'b0;
            bitIdx  <= '0;
            byteIdx <= '0;
            state   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (halfEnd) begin
            halfCnt <= '0;
            phaseHi <= !phaseHi;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
          if (fall) begin
            if (bitIdx == 3'd7) begin
              bitIdx  <= '0;
              byteIdx <= nextIdx;
              if (rxPhase) state <= ST_OUTB;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_OUTB: if (outReady) begin
          if (lastOut) begin
            csOnQ  <= 1'b0;
            gapCnt <= '0;
            state  <= ST_GAP;
          end else begin
            state <= ST_XFER;
          end
        end
        ST_GAP: begin
          if (gapCnt == GW'(CLK_DIV)) state <= ST_IDLE;
          else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk     = phaseHi;
  assign outValid = (state == ST_OUTB);
  assign done     = (state == ST_GAP) && (gapCnt == GW'(CLK_DIV));
  assign err      = errQ;

  AST_PARKED_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !sclk); // R11
  AST_VALID_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R11
  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !strobe.csOn); // R3
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strobe.csOn && $past(!strobe.csOn)); // R10
  AST_NONSPI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP) && !cfg.isSpi |=> !err && !strobe.csOn); // R1

endmodule

// File: rtl/spiBootReader.sv
module spiBootReader
  import spiBootPkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int BYTE_COUNT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [12:0] strap,
  input  logic        start,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs0N,
  output logic        cs1N,
  output logic [7:0]  outByte,
  output logic        outValid,
  input  logic        outReady,
  output logic        done,
  output logic        err
);

  bootCfg_t   cfg;
  spiStrobe_t strobe;

  spiBootCtrl #(.CLK_DIV(CLK_DIV), .BYTE_COUNT(BYTE_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfg(cfg), .outReady(outReady),
    .strobe(strobe), .sclk(sclk), .outValid(outValid), .done(done), .err(err)
  );

  spiBootDatapath u_dp (
    .clk(clk), .rstN(rstN), .strap(strap), .strobe(strobe), .miso(miso),
    .cfg(cfg), .cs0N(cs0N), .cs1N(cs1N), .mosi(mosi), .rxByte(outByte)
  );

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outByte)); // R11

endmodule

// File: tb/spiBootReader_bench.sv
module spiBootReader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int BYTE_COUNT = 6;
  localparam int NVEC       = 11;

  // {clock field, pin bit, addr width, cs field, index, device, kind}; kind 0 run, 1 error, 2 idle
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd2, 1'b0, 1'b1, 2'b10, 4'd0,  3'b110, 2'd0},
    {2'd0, 1'b0, 1'b0, 2'b01, 4'd5,  3'b110, 2'd0},
    {2'd2, 1'b0, 1'b1, 2'b00, 4'd3,  3'b110, 2'd1},
    {2'd2, 1'b0, 1'b1, 2'b01, 4'd15, 3'b110, 2'd0},
    {2'd2, 1'b0, 1'b1, 2'b11, 4'd3,  3'b110, 2'd1},
    {2'd0, 1'b0, 1'b1, 2'b10, 4'd9,  3'b110, 2'd0},
    {2'd2, 1'b1, 1'b1, 2'b10, 4'd2,  3'b110, 2'd1},
    {2'd1, 1'b0, 1'b1, 2'b10, 4'd2,  3'b110, 2'd1},
    {2'd2, 1'b0, 1'b1, 2'b10, 4'd4,  3'b101, 2'd2},
    {2'd3, 1'b0, 1'b0, 2'b01, 4'd2,  3'b110, 2'd1},
    {2'd2, 1'b0, 1'b0, 2'b10, 4'd1,  3'b110, 2'd0}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, outReady = 1'b0;
  logic [12:0] strap = '0;
  logic sclk, mosi, cs0N, cs1N, outValid, done, err;
  logic [7:0] outByte;
  logic slvMiso = 1'b0;
  int total = 0, bad = 0, cycles = 0;

  spiBootReader #(.CLK_DIV(CLK_DIV), .BYTE_COUNT(BYTE_COUNT)) u_spiBootReader (
    .clk(clk), .rstN(rstN), .strap(strap), .start(start), .miso(slvMiso),
    .sclk(sclk), .mosi(mosi), .cs0N(cs0N), .cs1N(cs1N), .outByte(outByte),
    .outValid(outValid), .outReady(outReady), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  function automatic logic [7:0] memByte(int a);
    return 8'((a * 7 + (a >> 8) * 13 + 8'h5A) & 255);
  endfunction

  // flash slave model
  wire csAnyN = cs0N & cs1N;
  int slvBits = 0;
  int slvHdrBits = 32;
  bit slvCpha = 1'b0;
  logic [31:0] slvHdr = '0;

  function automatic logic slaveBit(int n);
    int addr, d;
    logic [7:0] m;
    if (n < slvHdrBits) return 1'b0;
    addr = (slvHdrBits == 32) ? int'(slvHdr[23:0]) : int'(slvHdr[15:0]);
    d = n - slvHdrBits;
    m = memByte(addr + d / 8);
    return m[7 - (d % 8)];
  endfunction

  task automatic slaveCapture();
    if (slvBits < slvHdrBits) slvHdr = {slvHdr[30:0], mosi};
    slvBits++;
  endtask

  always @(negedge csAnyN) begin
    slvBits = 0;
    slvHdr = '0;
    if (!slvCpha) slvMiso = slaveBit(0);
  end
  always @(posedge sclk) if (!csAnyN) begin
    if (!slvCpha) slaveCapture();
    else slvMiso = slaveBit(slvBits);
  end
  always @(negedge sclk) if (!csAnyN) begin
    if (!slvCpha) slvMiso = slaveBit(slvBits);
    else slaveCapture();
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(cs0N && cs1N, "R10 reset chip selects", {cs0N, cs1N}, 3);
    check(!sclk && !outValid, "R6 reset sclk/valid", {sclk, outValid}, 0);
    check(!done && !err, "R1 reset done/err", {done, err}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [12:0] sw;
      int kind, base, idx, nBytes, mism, prevByte, relCyc, csRises, stalls;
      int riseCyc0, riseCyc1, nRise, cyc;
      bit wantCs1, sawCs0, sawCs1, sawSclk, sawDone, prevStall, prevSclk, prevCs, stallRun;
      string errReq;
      sw = VEC[v][14:2];
      kind = int'(VEC[v][1:0]);
      idx = int'(sw[6:3]);
      base = idx * 128;
      wantCs1 = (sw[8:7] == 2'b01);
      slvCpha = (sw[12:11] == 2'd0);
      slvHdrBits = sw[9] ? 32 : 24;
      stallRun = (v % 2) == 1;
      errReq = (sw[8:7] == 2'b00 || sw[8:7] == 2'b11) ? "R3" : (sw[10] ? "R5" : "R7");
      nBytes = 0; mism = 0; relCyc = 0; csRises = 0; stalls = 0; nRise = 0;
      riseCyc0 = 0; riseCyc1 = 0; prevByte = 0;
      sawCs0 = 0; sawCs1 = 0; sawSclk = 0; sawDone = 0; prevStall = 0;
      prevSclk = 0; prevCs = 1;
      strap = sw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (kind == 0) strap = ~sw; // R12: strap scrambled mid-transfer
      cyc = 0;
      while (cyc < ((kind == 0) ? 4000 : 40)) begin
        @(negedge clk);
        cyc++;
        outReady = stallRun ? ((cyc % 5) >= 2) : 1'b1;
        if (!cs0N) sawCs0 = 1;
        if (!cs1N) sawCs1 = 1;
        if (sclk) sawSclk = 1;
        if (sclk && !prevSclk) begin
          if (nRise == 0) riseCyc0 = cyc;
          if (nRise == 1) riseCyc1 = cyc;
          nRise++;
        end
        if (csAnyN && !prevCs) begin
          csRises++;
          relCyc = cyc;
        end
        if (prevStall) begin
          check(outValid && int'(outByte) == prevByte && !sclk, "R11 held byte",
                int'(outByte), prevByte);
        end
        prevStall = outValid && !outReady;
        if (prevStall) stalls++;
        prevByte = int'(outByte);
        if (outValid && outReady) begin
          if (outByte !== memByte(base + nBytes)) begin
            mism++;
            check(0, "R8 data byte", int'(outByte), int'(memByte(base + nBytes)));
          end
          nBytes++;
        end
        prevSclk = sclk;
        prevCs = csAnyN;
        if (done) begin
          sawDone = 1;
          check(cyc - relCyc >= CLK_DIV, "R10 release before done", cyc - relCyc, CLK_DIV);
          @(negedge clk);
          check(!done, "R10 done one cycle", int'(done), 0);
          check(!sclk && csAnyN, "R6 sclk idle low", int'(sclk), 0);
          break;
        end
      end
      if (kind == 0) begin
        check(sawDone, "R10 done seen", int'(sawDone), 1);
        check(nBytes == BYTE_COUNT, "R8 byte count", nBytes, BYTE_COUNT);
        check(mism == 0, "R6 data in clock mode", mism, 0);
        check(slvHdr[slvHdrBits-1 -: 8] == 8'h03, "R8 command", int'(slvHdr[slvHdrBits-1 -: 8]), 3);
        check(int'(sw[9] ? slvHdr[23:0] : {8'd0, slvHdr[15:0]}) == base, "R2 R4 address",
              int'(sw[9] ? slvHdr[23:0] : {8'd0, slvHdr[15:0]}), base);
        check(slvBits == slvHdrBits + 8 * BYTE_COUNT, "R4 clock count", slvBits,
              slvHdrBits + 8 * BYTE_COUNT);
        check(wantCs1 ? (sawCs1 && !sawCs0) : (sawCs0 && !sawCs1), "R3 chip select",
              {sawCs1, sawCs0}, wantCs1 ? 2 : 1);
        check(csRises == 1, "R10 select unbroken", csRises, 1);
        check(riseCyc1 - riseCyc0 == CLK_DIV, "R9 sclk period", riseCyc1 - riseCyc0, CLK_DIV);
        check(!err, "R12 error cleared", int'(err), 0);
        if (stallRun) check(stalls > 0, "R11 stalls applied", stalls, 1);
      end else if (kind == 1) begin
        check(err, {errReq, " error flag"}, int'(err), 1);
        check(!sawCs0 && !sawCs1 && !sawSclk && !sawDone, {errReq, " no activity"},
              {sawCs0, sawCs1, sawSclk, sawDone}, 0);
      end else begin
        check(!err && !sawCs0 && !sawCs1 && !sawSclk && !sawDone, "R1 non-SPI quiet",
              {err, sawCs0, sawCs1, sawSclk, sawDone}, 0);
      end
      outReady = 1'b0;
      repeat (3) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule